// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target

This block is an I2C target that exposes a small internal register array to a bus controller. Its 7-bit bus address is the fixed prefix `0001` followed by three strap inputs, so up to eight of these targets can share one bus. SDA and SCL are oversampled on the system clock. Each line passes through a synchronizer, and edge detection on the system clock recovers bus clock edges, start conditions and stop conditions. The SDA output is open-drain and is modelled as a single drive-low enable.

A write transfer always begins with a pointer byte. The pointer persists after the transfer. Any further bytes in the same write land at successive register locations. A read transfer returns bytes from the current pointer and advances it after every byte. To read a chosen location, the controller first issues a short write that carries only the pointer byte, and then performs the read. A read that stops early leaves the pointer at the location after the last byte sent, so the next read continues from there.

The register array has a synchronous read port and is written so that block RAM can hold it.

Top module: `i2c_strap_regs`

## Requirements
- R1: The target acknowledges a controller address byte whose upper seven bits equal `0001` followed by strap bits [2:0] (bit 0 of the byte is the read/write flag, 1 = read). It acknowledges by holding SDA low through the ninth SCL clock of that byte. A change of the strap inputs between transfers moves the address the target answers to.
- R2: After an address byte that does not match, the target never drives SDA and changes no register until the next start condition.
- R3: In a write transfer, the first byte after the address loads the register pointer with its low `REG_AW` bits.
- R4: Each later byte of the same write is stored at the pointer, and the pointer then advances by one.
- R5: A read transfer sends register bytes MSB first, beginning at the current pointer. The pointer advances by one after every byte sent.
- R6: The pointer persists across transfers. A read that follows a pointer-only write starts at that pointer, and a read that ends early resumes at the next location on the following read.
- R7: Every byte received in a write transfer to this target is acknowledged in its ninth clock.
- R8: When the controller does not acknowledge a read byte, the target leaves SDA released until the next start condition.
- R9: A start condition seen in any state, including a repeated start inside a transfer, releases SDA and returns the target to the address phase.
- R10: While reset is asserted and on the cycle after it, SDA is released.
- R11: The pointer wraps from the last array location to location 0, for both writes and reads.
- R12: The target changes its SDA drive only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr | input | 3 | Low three bits of the bus address |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_drive_low | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
Two functions can happen in the same step. A data byte's write into the array and its pointer advance are issued on one SCL edge. A register read also happens while the pointer moves after each transmitted byte. The bench provokes this with multi-byte writes that cross the top of the array, followed by reads that begin just below the wrap point. It judges the result by comparing every returned byte against a behavioural model of the array and pointer. On every clock, the bench also checks that SDA stays released during a non-matching transfer and after a controller non-acknowledge.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;

  // fixed upper part of the 7-bit bus address
  localparam logic [3:0] BUS_ADDR_PREFIX = 4'b0001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_q;
  logic              sda_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_in;
          sda_chain <= sda_in;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[STAGES-2:0], scl_in};
          sda_chain <= {sda_chain[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_s = scl_chain[STAGES-1];
  assign sda_s = sda_chain[STAGES-1];

  // previous samples for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // write port plus registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_strap_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    strap_addr,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic          drive_low,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] ptr,
  output logic          ptr_load,
  output tgt_state_e    state
);

  localparam logic [AW-1:0] PTR_ONE = AW'(1);

  tgt_state_e    state_q;
  logic [3:0]    cnt_q;
  logic [7:0]    shreg_q;
  logic          full_q;
  logic          first_q;
  logic          rw_q;
  logic          nack_q;
  logic [AW-1:0] ptr_q;
  logic          drv_q;
  logic          we_q;
  logic [AW-1:0] waddr_q;
  logic [7:0]    wdata_q;
  logic          load_q;

  logic addr_hit;
  assign addr_hit = (shreg_q[7:1] == {BUS_ADDR_PREFIX, strap_addr});

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      full_q  <= 1'b0;
      first_q <= 1'b1;
      rw_q    <= 1'b0;
      nack_q  <= 1'b1;
      ptr_q   <= '0;
      drv_q   <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      load_q  <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      load_q <= 1'b0;
      if (start_det) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        full_q  <= 1'b0;
        first_q <= 1'b1;
        drv_q   <= 1'b0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
        full_q  <= 1'b0;
        drv_q   <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_WR_BYTE: begin
            if (scl_rise && !full_q) begin
              shreg_q <= {shreg_q[6:0], sda_s};
              cnt_q   <= cnt_q + 4'd1;
              if (cnt_q == 4'd7) full_q <= 1'b1;
            end else if (scl_fall && full_q) begin
              full_q <= 1'b0;
              cnt_q  <= '0;
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  rw_q    <= shreg_q[0];
                  drv_q   <= 1'b1;
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                drv_q   <= 1'b1;
                state_q <= ST_WR_ACK;
                if (first_q) begin
                  ptr_q   <= shreg_q[AW-1:0];
                  first_q <= 1'b0;
                  load_q  <= 1'b1;
                end else begin
                  we_q    <= 1'b1;
                  waddr_q <= ptr_q;
                  wdata_q <= shreg_q;
                  ptr_q   <= ptr_q + PTR_ONE;
                end
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                shreg_q <= rd_data;
                drv_q   <= ~rd_data[7];
                state_q <= ST_RD_BYTE;
              end else begin
                drv_q   <= 1'b0;
                state_q <= ST_WR_BYTE;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              drv_q   <= 1'b0;
              state_q <= ST_WR_BYTE;
            end
          end
          ST_RD_BYTE: begin
            if (scl_fall) begin
              if (cnt_q == 4'd7) begin
                drv_q   <= 1'b0;
                ptr_q   <= ptr_q + PTR_ONE;
                state_q <= ST_RD_ACK;
              end else begin
                shreg_q <= {shreg_q[6:0], 1'b0};
                drv_q   <= ~shreg_q[6];
                cnt_q   <= cnt_q + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              cnt_q <= '0;
              if (!nack_q) begin
                shreg_q <= rd_data;
                drv_q   <= ~rd_data[7];
                state_q <= ST_RD_BYTE;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign drive_low = drv_q;
  assign mem_we    = we_q;
  assign mem_waddr = waddr_q;
  assign mem_wdata = wdata_q;
  assign ptr       = ptr_q;
  assign ptr_load  = load_q;
  assign state     = state_q;

endmodule

// File: rtl/i2c_strap_regs.sv
module i2c_strap_regs
  import i2c_strap_pkg::*;
#(
  parameter int REG_AW      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] strap_addr,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_drive_low
);

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [7:0]        rd_data;
  logic              mem_we;
  logic [REG_AW-1:0] mem_waddr;
  logic [7:0]        mem_wdata;
  logic [REG_AW-1:0] ptr;
  logic              ptr_load;
  tgt_state_e        state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_target_fsm #(.AW(REG_AW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .strap_addr (strap_addr),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .rd_data    (rd_data),
    .drive_low  (sda_drive_low),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .ptr        (ptr),
    .ptr_load   (ptr_load),
    .state      (state)
  );

  i2c_reg_array #(.AW(REG_AW), .DW(8)) u_regs (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/i2c_strap_regs_checker.sv
module i2c_strap_regs_checker
  import i2c_strap_pkg::*;
#(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_s,
  input logic          start_det,
  input logic          sda_drive_low,
  input tgt_state_e    state,
  input logic [AW-1:0] ptr,
  input logic          ptr_load,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr
);

  AST_RESET_RELEASE: assert property (@(posedge clk)
    rst |=> !sda_drive_low); // R10

  AST_DRIVE_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_drive_low) |-> !$past(scl_s)); // R12

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_drive_low); // R2

  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR) && !sda_drive_low); // R9

  AST_WRITE_THEN_STEP: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (ptr == AW'(mem_waddr + 1'b1))); // R4

  AST_PTR_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ptr) && !ptr_load) |-> (ptr == AW'($past(ptr) + 1'b1))); // R5

endmodule

bind i2c_strap_regs i2c_strap_regs_checker #(.AW(REG_AW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .scl_s         (scl_s),
  .start_det     (start_det),
  .sda_drive_low (sda_drive_low),
  .state         (state),
  .ptr           (ptr),
  .ptr_load      (ptr_load),
  .mem_we        (mem_we),
  .mem_waddr     (mem_waddr)
);

// File: tb/i2c_strap_regs_bench.sv
`timescale 1ns/1ps
module i2c_strap_regs_bench;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int Q     = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_drv;
  logic       sda_bus;

  assign sda_bus = sda_m & ~sda_drv;

  always #10 clk = ~clk;

  i2c_strap_regs #(.REG_AW(AW), .SYNC_STAGES(2)) u_i2c_strap_regs (
    .clk           (clk),
    .rst           (rst),
    .strap_addr    (strap),
    .scl_in        (scl_m),
    .sda_in        (sda_bus),
    .sda_drive_low (sda_drv)
  );

  int compared   = 0;
  int mismatched = 0;
  bit quiet      = 1'b0;
  bit done       = 1'b0;
  string quiet_req = "R2";

  // behavioural model of array and pointer
  logic [7:0] model_mem [DEPTH];
  int         model_ptr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison: target must stay off SDA when the model says so
  always @(negedge clk) begin
    if (!rst && quiet && !done) begin
      compared++;
      if (sda_drv) begin
        mismatched++;
        $display("FAIL %s actual=%0d expected=%0d at %0t", quiet_req, sda_drv, 0, $time);
      end
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    quiet = 1'b0;
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    quiet = 1'b0;
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq(); wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    b = sda_bus; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack_n);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack_n);
  endtask

  task automatic get_byte(input logic nack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(nack);
  endtask

  // write transfer: pointer byte then data bytes
  task automatic write_regs(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d[$]);
    logic ack_n;
    bus_start();
    put_byte({a, 1'b0}, ack_n);
    chk(ack_n == 1'b0, "R1 address ack", ack_n, 0);
    put_byte(p, ack_n);
    chk(ack_n == 1'b0, "R7 pointer byte ack", ack_n, 0);
    model_ptr = p % DEPTH;  // R3
    foreach (d[i]) begin
      put_byte(d[i], ack_n);
      chk(ack_n == 1'b0, "R7 data byte ack", ack_n, 0);
      model_mem[model_ptr] = d[i];  // R4
      model_ptr = (model_ptr + 1) % DEPTH;
    end
    bus_stop();
  endtask

  // read transfer of n bytes, last one not acknowledged
  task automatic read_regs(input logic [6:0] a, input int n, input string req);
    logic ack_n;
    logic [7:0] v;
    bus_start();
    put_byte({a, 1'b1}, ack_n);
    chk(ack_n == 1'b0, "R1 read address ack", ack_n, 0);
    for (int i = 0; i < n; i++) begin
      get_byte(i == n - 1, v);
      chk(v == model_mem[model_ptr], req, v, model_mem[model_ptr]);
      model_ptr = (model_ptr + 1) % DEPTH;
    end
    quiet_req = "R8";
    quiet = 1'b1;
    wq(); wq();
    chk(sda_bus == 1'b1, "R8 released after nack", sda_bus, 1);
    bus_stop();
  endtask

  initial begin
    logic ack_n;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    chk(sda_drv == 1'b0, "R10 reset release", sda_drv, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sda_drv == 1'b0, "R10 after reset", sda_drv, 0);
    quiet_req = "R10"; quiet = 1'b1;
    wq();

    // R3 R4 R7: pointer then three data bytes
    write_regs(7'h0D, 8'h02, '{8'hAA, 8'hBB, 8'hCC});
    // R6: pointer-only write then read back, R5 increment
    write_regs(7'h0D, 8'h02, '{});
    read_regs(7'h0D, 3, "R5 read data");
    // R6: interrupted read resumes
    write_regs(7'h0D, 8'h03, '{});
    read_regs(7'h0D, 1, "R6 first read");
    read_regs(7'h0D, 1, "R6 resumed read");

    // R2: non-matching address ignored
    bus_start();
    quiet_req = "R2"; quiet = 1'b1;
    put_byte({7'h0E, 1'b0}, ack_n);
    chk(ack_n == 1'b1, "R2 no address ack", ack_n, 1);
    put_byte(8'h02, ack_n);
    chk(ack_n == 1'b1, "R2 no pointer ack", ack_n, 1);
    put_byte(8'h55, ack_n);
    chk(ack_n == 1'b1, "R2 no data ack", ack_n, 1);
    bus_stop();
    write_regs(7'h0D, 8'h02, '{});
    read_regs(7'h0D, 1, "R2 register unchanged");

    // R9: repeated start into a read
    bus_start();
    put_byte({7'h0D, 1'b0}, ack_n);
    chk(ack_n == 1'b0, "R9 address ack", ack_n, 0);
    put_byte(8'h00, ack_n);
    model_ptr = 0;
    put_byte(8'h11, ack_n);
    model_mem[0] = 8'h11;
    put_byte(8'h22, ack_n);
    model_mem[1] = 8'h22;
    model_ptr = 2;
    chk(ack_n == 1'b0, "R7 ack before restart", ack_n, 0);
    bus_rstart();
    put_byte({7'h0D, 1'b1}, ack_n);
    chk(ack_n == 1'b0, "R9 read address after restart", ack_n, 0);
    get_byte(1'b1, v);
    chk(v == model_mem[model_ptr], "R9 read after restart", v, model_mem[model_ptr]);
    model_ptr = (model_ptr + 1) % DEPTH;
    bus_stop();

    // R11: wrap on write and read
    write_regs(7'h0D, 8'h0F, '{8'h77, 8'h88, 8'h99});
    write_regs(7'h0D, 8'h0E, '{});
    model_mem[14] = model_mem[14];
    write_regs(7'h0D, 8'h0E, '{8'h66});
    write_regs(7'h0D, 8'h0E, '{});
    read_regs(7'h0D, 4, "R11 wrap read");
    // pointer wraps in read from 15 into 0
    write_regs(7'h0D, 8'h0F, '{});
    read_regs(7'h0D, 2, "R11 read across top");

    // R1: strap change moves the address
    strap = 3'b010;
    wq();
    bus_start();
    quiet_req = "R2"; quiet = 1'b1;
    put_byte({7'h0D, 1'b0}, ack_n);
    chk(ack_n == 1'b1, "R1 old address ignored", ack_n, 1);
    bus_stop();
    write_regs(7'h0A, 8'h05, '{8'h3C});
    write_regs(7'h0A, 8'h05, '{});
    read_regs(7'h0A, 1, "R1 new address read");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule